// File: doc/BRIEF.md
# Set/Clear Pair Flag Machine

This block watches a serial bit stream, one bit per clock, and holds a flag on its output. The flag rises when a zero is followed by a one, and it drops only when a zero is followed by another zero. Any other pair leaves the flag as it is. The output is not a one-cycle detection pulse. It is a held level that remembers the last setting or clearing event.

The clearing pair and the setting pair may share a bit. The second zero of a clearing pair counts as the leading zero of a setting pair, so a one that follows it sets the flag again at once. The flag is a Mealy output. It changes in the same cycle as the input bit that completes a pair, and the state register takes up the change at the next rising edge.

Four states are enough. Each state holds two facts: whether the flag is high, and whether the last accepted bit was a zero. These two facts fill a 2-bit state register. A synchronous active-high reset returns the machine to "flag low, no zero seen".

Top module: `setclr_pair_fsm`

## Requirements
- R1: While `rst` is high, `z_o` is 0 for any `x_i`. In the first cycle after reset is released, `z_o` is 0 for any `x_i`, because no zero has been recorded yet.
- R2: When the previous accepted bit was 0 and `x_i` is 1, `z_o` is 1 in that same cycle.
- R3: When the flag is high, the previous accepted bit was 0 and `x_i` is 0, `z_o` is 0 in that same cycle.
- R4: When the flag is high and the previous accepted bit was 1, `z_o` stays 1 for either value of `x_i`. Once high, the flag is cleared by nothing except a 00 pair.
- R5: When the flag is low, the pairs 11, 10 and 00 leave `z_o` at 0. Only a 01 pair raises it.
- R6: After a 00 pair clears the flag, a 1 in the very next cycle sets `z_o` to 1 in that cycle.
- R7: When the stream 0,1,0,1,0,0,1,0,0 is applied right after reset, `z_o` reads 0,1,1,1,1,0,1,1,0 cycle for cycle.
- R8: A reset in the middle of a stream discards both the flag and the record of the last bit. If the last bit before reset was 0, a 1 in the first cycle after reset still gives `z_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_i | input | 1 | Serial input bit, one per clock |
| z_o | output | 1 | Held flag, Mealy output |

## Verification
The hardest situation to reach from the ports is the shared-bit overlap. The flag must be high, two zeros must clear it, and a one must follow at once, so the output drops for exactly one cycle and then rises again. The random phase draws bits with a bias toward zeros, so runs of 0,0,1 come up often while the flag is high. Directed sequences force this case, and they also cover a reset that lands just after a zero. The reference model follows only the flag and whether the last bit was a zero, and it compares `z_o` on every cycle.

// File: rtl/setclr_pair_pkg.sv
package setclr_pair_pkg;

  // Bit 1 holds the flag, bit 0 records that the last accepted bit was zero.
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_LOW_ONE   = 2'b00,  // flag low, last bit 1 or nothing seen yet
    ST_LOW_ZERO  = 2'b01,  // flag low, last bit 0
    ST_HIGH_ONE  = 2'b10,  // flag high, last bit 1
    ST_HIGH_ZERO = 2'b11   // flag high, last bit 0
  } pair_state_e;

  localparam pair_state_e RESET_STATE = ST_LOW_ONE;

endpackage

// File: rtl/setclr_pair_next.sv
module setclr_pair_next
  import setclr_pair_pkg::*;
(
  input  pair_state_e cur_s,
  input  logic        bit_i,
  output pair_state_e nxt_s
);

  always_comb begin
    unique case (cur_s)
      ST_LOW_ONE:   nxt_s = bit_i ? ST_LOW_ONE  : ST_LOW_ZERO;
      ST_LOW_ZERO:  nxt_s = bit_i ? ST_HIGH_ONE : ST_LOW_ZERO;
      ST_HIGH_ONE:  nxt_s = bit_i ? ST_HIGH_ONE : ST_HIGH_ZERO;
      // a clearing zero is kept as a possible leading zero of the next set
      ST_HIGH_ZERO: nxt_s = bit_i ? ST_HIGH_ONE : ST_LOW_ZERO;
      default:      nxt_s = RESET_STATE;
    endcase
  end

endmodule

// File: rtl/setclr_pair_out.sv
module setclr_pair_out
  import setclr_pair_pkg::*;
(
  input  pair_state_e cur_s,
  input  logic        bit_i,
  input  logic        hold_low,
  output logic        flag_o
);

  logic raw_flag;

  always_comb begin
    unique case (cur_s)
      ST_LOW_ONE:   raw_flag = 1'b0;
      ST_LOW_ZERO:  raw_flag = bit_i;
      ST_HIGH_ONE:  raw_flag = 1'b1;
      ST_HIGH_ZERO: raw_flag = bit_i;
      default:      raw_flag = 1'b0;
    endcase
  end

  assign flag_o = raw_flag & ~hold_low;

endmodule

// File: rtl/setclr_pair_state_reg.sv
module setclr_pair_state_reg
  import setclr_pair_pkg::*;
#(
  parameter pair_state_e INIT_S = RESET_STATE
) (
  input  logic        clk,
  input  logic        rst,
  input  pair_state_e d_s,
  output pair_state_e q_s
);

  always_ff @(posedge clk) begin
    if (rst) q_s <= INIT_S;
    else     q_s <= d_s;
  end

endmodule

// File: rtl/setclr_pair_fsm.sv
module setclr_pair_fsm
  import setclr_pair_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x_i,
  output logic z_o
);

  pair_state_e state_q;
  pair_state_e state_d;

  setclr_pair_state_reg #(
    .INIT_S (RESET_STATE)
  ) u_state (
    .clk (clk),
    .rst (rst),
    .d_s (state_d),
    .q_s (state_q)
  );

  setclr_pair_next u_next (
    .cur_s (state_q),
    .bit_i (x_i),
    .nxt_s (state_d)
  );

  setclr_pair_out u_out (
    .cur_s    (state_q),
    .bit_i    (x_i),
    .hold_low (rst),
    .flag_o   (z_o)
  );

endmodule

// File: rtl/setclr_pair_fsm_chk.sv
module setclr_pair_fsm_chk (
  input logic clk,
  input logic rst,
  input logic x_i,
  input logic z_o
);

  logic seen_q;   // at least one bit accepted since reset
  logic prev_x_q;
  logic prev_z_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      prev_x_q <= 1'b1;
      prev_z_q <= 1'b0;
    end else begin
      seen_q   <= 1'b1;
      prev_x_q <= x_i;
      prev_z_q <= z_o;
    end
  end

  p_first_low_r1: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> !z_o);

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !prev_x_q && x_i) |-> z_o);

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (seen_q && prev_z_q && !prev_x_q && !x_i) |-> !z_o);

  p_hold_high_r4: assert property (@(posedge clk) disable iff (rst)
    (seen_q && prev_z_q && prev_x_q) |-> z_o);

  p_keep_low_r5: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !prev_z_q && !(!prev_x_q && x_i)) |-> !z_o);

  p_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !prev_z_q && !prev_x_q && x_i) |-> z_o);

endmodule

bind setclr_pair_fsm setclr_pair_fsm_chk u_chk (
  .clk (clk),
  .rst (rst),
  .x_i (x_i),
  .z_o (z_o)
);

// File: tb/setclr_pair_fsm_bench.sv
module setclr_pair_fsm_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_STEPS = 4000;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_i = 1'b0;
  logic z_o;

  int checks = 0;
  int errors = 0;

  // reference model: flag level and "last accepted bit was zero"
  bit m_flag  = 1'b0;
  bit m_prev0 = 1'b0;

  setclr_pair_fsm u_setclr_pair_fsm (
    .clk (clk),
    .rst (rst),
    .x_i (x_i),
    .z_o (z_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_z(bit r, bit flag, bit prev0, bit b);
    if (r) return 1'b0;
    if (prev0) return b;     // 01 sets, 00 clears
    return flag;             // a pair not starting with 0 changes nothing
  endfunction

  function automatic string tag_of(bit r, bit flag, bit prev0, bit b);
    if (r) return "R1";
    if (prev0 && b) return "R2";
    if (prev0 && !b && flag) return "R3";
    if (flag) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, bit expv);
    checks++;
    if (z_o !== expv) begin
      errors++;
      $display("FAIL %s: z_o actual %b expected %b at %0t", tag, z_o, expv, $time);
    end
  endtask

  // Drive one bit between edges, check the Mealy output, advance the model.
  task automatic step(bit r, bit b, string tag_over);
    bit e;
    string t;
    @(negedge clk);
    rst = r;
    x_i = b;
    #1;
    e = exp_z(r, m_flag, m_prev0, b);
    t = (tag_over != "") ? tag_over : tag_of(r, m_flag, m_prev0, b);
    check(t, e);
    if (r) begin
      m_flag  = 1'b0;
      m_prev0 = 1'b0;
    end else begin
      m_flag  = e;
      m_prev0 = !b;
    end
  endtask

  initial begin
    bit [8:0] ex_x;
    bit [8:0] ex_z;
    int unsigned seed_sink;
    seed_sink = $urandom(32'h00C0FFEE);

    // R1: reset holds the output low for either input value
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    // R1: first bit after reset cannot set the flag
    step(1'b0, 1'b1, "R1");

    // R7: example stream, expected values written MSB-first
    step(1'b1, 1'b0, "R1");
    ex_x = 9'b010100100;
    ex_z = 9'b011110110;
    for (int i = 8; i >= 0; i--) begin
      step(1'b0, ex_x[i], "");
      checks++;
      if (z_o !== ex_z[i]) begin
        errors++;
        $display("FAIL R7: z_o actual %b expected %b at bit %0d", z_o, ex_z[i], 8 - i);
      end
    end

    // R6: set, clear by 00, then a 1 immediately sets again
    step(1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, "R6");
    // R4: ones and a lone zero keep it high
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, "R4");

    // R8: reset right after a zero, then a 1 must not set
    step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, "R1");
    step(1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, "R5");

    // random phase, biased toward zeros, with rare mid-stream resets
    for (int n = 0; n < RAND_STEPS; n++) begin
      bit r;
      bit b;
      r = ($urandom_range(0, 199) == 0);
      b = ($urandom_range(0, 99) < 40);
      step(r, b, "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule